// File: doc/BRIEF.md
# Rotatable Six-Way Priority Arbiter

The block picks one winner from a set of request lines and reports it both as a one-hot grant vector and as a 3-bit winner number. In its default build there are six requests, numbered 0 to 5. Request 0 always beats every other line, and request 5 always loses to every other line. The four requests in the middle (1 to 4) follow a circular order. A 2-bit select register chooses where that circle starts: a select value of s makes request s+1 the strongest of the middle four.

The select register has two sources. It can be loaded directly through a write port. When the rotate-mode input is high, it also updates itself on every clock edge where the service strobe marks the current winner as handled. When the winner is a middle request, the register moves so that this request becomes the weakest of the middle four. This gives round-robin fairness among the middle four while the two end requests keep their fixed rank.

A build parameter removes the two end requests. That build is a plain four-way rotating arbiter over requests 1 to 4. The grant is combinational from the requests and the current select value. The select value itself is registered.

Top module: `rot_arb6`

## Requirements
- R1: With select 00, and with select 00 in every case where request 0 or request 5 competes, the winner is the first active request in the order 0,1,2,3,4,5. Request 0 wins whenever it is active, and request 5 wins only when it is the only active line.
- R2: With select 01 the middle order is 2,3,4,1. With select 10 it is 3,4,1,2. With select 11 it is 4,1,2,3. Requests 0 and 5 remain first and last in all three cases.
- R3: With no active request, `grant` is all zeros, `valid` is 0 and `win_idx` is 0. A service strobe in such a cycle leaves the select register unchanged.
- R4: `grant` has at most one bit set, that bit is always an active request, and `win_idx` equals the number of the granted request.
- R5: With `rot_mode` at 0, the service strobe never changes the select register.
- R6: With `rot_mode` at 1, servicing a middle winner sets the select register at the next clock edge. Winner 1 sets it to 01, winner 2 to 10, winner 3 to 11 and winner 4 to 00. In every case the new value is the winner number modulo 4.
- R7: Servicing request 0 or request 5 leaves the select register unchanged in either mode.
- R8: A write loads `sel_wr_data` into the select register at the next clock edge. When a write and a rotating service occur in the same cycle, the written value is the one kept.
- R9: Synchronous reset sets the select register to 00.
- R10: With `PINNED_ENDS`=0, the block has four request bits. Bit i of `req` and `grant` stands for request i+1, and `win_idx` reports that number (1 to 4). The order rules for the middle four and the update rules of R6 and R8 apply unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req | input | REQ_W (6, or 4 when PINNED_ENDS=0) | Request lines |
| rot_mode | input | 1 | 1 = rotate the select value on service, 0 = fixed |
| sel_wr_en | input | 1 | Load strobe for the select register |
| sel_wr_data | input | 2 | Value to load into the select register |
| service | input | 1 | Marks the current winner as serviced in this cycle |
| grant | output | REQ_W | One-hot grant, combinational |
| win_idx | output | 3 | Number of the winning request |
| valid | output | 1 | High when any request is active |
| sel_q | output | 2 | Current select register value |

## Verification
`grant`, `win_idx` and `valid` are combinational, so they are due in the same cycle the requests are driven. The bench compares them 5 ns after the falling edge on which it drove those inputs. `sel_q` changes only at a rising edge, so a write or a service has an effect one cycle later. To match this, each scoreboard item records the select value that the reference model held before that cycle's edge. The monitor compares the item against the outputs sampled in the same low phase. A four-request instance runs beside the default one on the same stimulus, and it is checked against its own reference model.

// File: rtl/rot_arb_pkg.sv
package rot_arb_pkg;
  localparam int SEL_W = 2;
  localparam int MID_N = 4;
  localparam int IDX_W = 3;
endpackage

// File: rtl/rot_arb_mid_pick.sv
module rot_arb_mid_pick
  import rot_arb_pkg::*;
(
  input  logic [MID_N-1:0] mid_req,
  input  logic [SEL_W-1:0] sel,
  output logic [MID_N-1:0] mid_gnt,
  output logic             mid_hit,
  output logic [SEL_W-1:0] mid_next
);
  // Position j stands for request j+1. A select value of s starts the scan at position s.
  always_comb begin
    mid_gnt  = '0;
    mid_hit  = 1'b0;
    mid_next = '0;
    for (int o = 0; o < MID_N; o++) begin
      int p;
      p = (int'(sel) + o) % MID_N;
      if (!mid_hit && mid_req[p]) begin
        mid_gnt[p] = 1'b1;
        mid_hit    = 1'b1;
        mid_next   = SEL_W'((p + 1) % MID_N);
      end
    end
  end
endmodule

// File: rtl/rot_arb_sel_reg.sv
module rot_arb_sel_reg
  import rot_arb_pkg::*;
(
  input  logic             clk,
  input  logic             rst,
  input  logic             wr_en,
  input  logic [SEL_W-1:0] wr_data,
  input  logic             upd_en,
  input  logic [SEL_W-1:0] upd_val,
  output logic [SEL_W-1:0] sel_q
);
  always_ff @(posedge clk) begin
    if (rst)         sel_q <= '0;
    else if (wr_en)  sel_q <= wr_data;
    else if (upd_en) sel_q <= upd_val;
  end
endmodule

// File: rtl/rot_arb6.sv
module rot_arb6
  import rot_arb_pkg::*;
#(
  parameter bit PINNED_ENDS = 1'b1,
  localparam int REQ_W   = PINNED_ENDS ? MID_N + 2 : MID_N,
  localparam int LBL_ADD = PINNED_ENDS ? 0 : 1
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [REQ_W-1:0] req,
  input  logic             rot_mode,
  input  logic             sel_wr_en,
  input  logic [1:0]       sel_wr_data,
  input  logic             service,
  output logic [REQ_W-1:0] grant,
  output logic [2:0]       win_idx,
  output logic             valid,
  output logic [1:0]       sel_q
);
  logic [MID_N-1:0] mid_req, mid_gnt;
  logic             mid_hit, mid_won;
  logic [SEL_W-1:0] mid_next;

  generate
    if (PINNED_ENDS) begin : g_pinned
      assign mid_req = req[MID_N:1];
      always_comb begin
        grant = '0;
        if (req[0])       grant[0] = 1'b1;
        else if (mid_hit) grant[MID_N:1] = mid_gnt;
        else if (req[REQ_W-1]) grant[REQ_W-1] = 1'b1;
      end
      assign mid_won = mid_hit & ~req[0];
    end else begin : g_plain
      assign mid_req = req;
      assign grant   = mid_gnt;
      assign mid_won = mid_hit;
    end
  endgenerate

  rot_arb_mid_pick u_pick (
    .mid_req (mid_req),
    .sel     (sel_q),
    .mid_gnt (mid_gnt),
    .mid_hit (mid_hit),
    .mid_next(mid_next)
  );

  always_comb begin
    win_idx = '0;
    for (int i = 0; i < REQ_W; i++)
      if (grant[i]) win_idx = IDX_W'(i + LBL_ADD);
  end

  assign valid = |req;

  rot_arb_sel_reg u_sel (
    .clk    (clk),
    .rst    (rst),
    .wr_en  (sel_wr_en),
    .wr_data(sel_wr_data),
    .upd_en (rot_mode & service & mid_won),
    .upd_val(mid_next),
    .sel_q  (sel_q)
  );
endmodule

// File: rtl/rot_arb6_chk.sv
module rot_arb6_chk #(
  parameter bit PINNED_ENDS = 1'b1,
  localparam int REQ_W = PINNED_ENDS ? 6 : 4
) (
  input logic             clk,
  input logic             rst,
  input logic [REQ_W-1:0] req,
  input logic             rot_mode,
  input logic             sel_wr_en,
  input logic [1:0]       sel_wr_data,
  input logic             service,
  input logic [REQ_W-1:0] grant,
  input logic [2:0]       win_idx,
  input logic             valid,
  input logic [1:0]       sel_q
);
  p_onehot_r4: assert property (@(posedge clk) disable iff (rst) $onehot0(grant));
  p_grant_active_r4: assert property (@(posedge clk) disable iff (rst) (grant & ~req) == '0);
  p_idle_r3: assert property (@(posedge clk) disable iff (rst)
    (req == '0) |-> (grant == '0 && win_idx == 3'd0));
  p_busy_grant_r4: assert property (@(posedge clk) disable iff (rst)
    (req != '0) |-> (grant != '0));
  p_fixed_r5: assert property (@(posedge clk) disable iff (rst)
    (!rot_mode && !sel_wr_en) |=> $stable(sel_q));
  p_idle_hold_r3: assert property (@(posedge clk) disable iff (rst)
    (req == '0 && !sel_wr_en) |=> $stable(sel_q));
  p_write_r8: assert property (@(posedge clk) disable iff (rst)
    sel_wr_en |=> (sel_q == $past(sel_wr_data)));
  p_rotate_r6: assert property (@(posedge clk) disable iff (rst)
    (rot_mode && service && !sel_wr_en && valid && win_idx >= 3'd1 && win_idx <= 3'd4)
    |=> (sel_q == $past(win_idx[1:0])));
  generate
    if (PINNED_ENDS) begin : g_ends
      p_top_r1: assert property (@(posedge clk) disable iff (rst) req[0] |-> grant[0]);
      p_ends_hold_r7: assert property (@(posedge clk) disable iff (rst)
        (!sel_wr_en && (grant[0] || grant[REQ_W-1])) |=> $stable(sel_q));
    end
  endgenerate
endmodule

bind rot_arb6 rot_arb6_chk #(.PINNED_ENDS(PINNED_ENDS)) u_chk (
  .clk(clk), .rst(rst), .req(req), .rot_mode(rot_mode), .sel_wr_en(sel_wr_en),
  .sel_wr_data(sel_wr_data), .service(service), .grant(grant), .win_idx(win_idx),
  .valid(valid), .sel_q(sel_q)
);

// File: tb/tb_rot_arb6.sv
module tb_rot_arb6;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic [5:0] req = '0;
  logic rot_mode = 1'b0, sel_wr_en = 1'b0, service = 1'b0;
  logic [1:0] sel_wr_data = '0;
  logic [5:0] grant;  logic [2:0] win_idx;  logic valid;  logic [1:0] sel_q;
  logic [3:0] grant4; logic [2:0] win_idx4; logic valid4; logic [1:0] sel_q4;

  always #10 clk = ~clk;

  rot_arb6 #(.PINNED_ENDS(1'b1)) dut (
    .clk(clk), .rst(rst), .req(req), .rot_mode(rot_mode), .sel_wr_en(sel_wr_en),
    .sel_wr_data(sel_wr_data), .service(service), .grant(grant), .win_idx(win_idx),
    .valid(valid), .sel_q(sel_q));

  rot_arb6 #(.PINNED_ENDS(1'b0)) dut4 (
    .clk(clk), .rst(rst), .req(req[4:1]), .rot_mode(rot_mode), .sel_wr_en(sel_wr_en),
    .sel_wr_data(sel_wr_data), .service(service), .grant(grant4), .win_idx(win_idx4),
    .valid(valid4), .sel_q(sel_q4));

  typedef struct {
    string      tag;
    logic [5:0] g;  logic [2:0] i;  logic v;  logic [1:0] s;
    logic [3:0] g4; logic [2:0] i4; logic v4; logic [1:0] s4;
  } item_t;

  item_t sb[$];
  int n_cmp = 0, n_bad = 0;
  logic [1:0] m_sel = 2'd0, m_sel4 = 2'd0;
  bit done = 0;

  // Reference order: 0 first, then the middle four from label sel+1 in a circle, then 5.
  function automatic int ref_label(logic [5:0] r, logic [1:0] s, bit pinned);
    if (pinned && r[0]) return 0;
    for (int o = 0; o < 4; o++) begin
      int k;
      k = ((int'(s) + o) % 4) + 1;
      if (r[k]) return k;
    end
    if (pinned && r[5]) return 5;
    return -1;
  endfunction

  task automatic cmp(string tag, string what, int act, int exp);
    n_cmp++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, exp);
    end
  endtask

  task automatic step(string tag, logic [5:0] r, logic m, logic we, logic [1:0] wd, logic sv);
    item_t it;
    int l6, l4;
    @(negedge clk);
    req = r; rot_mode = m; sel_wr_en = we; sel_wr_data = wd; service = sv;
    l6 = ref_label(r, m_sel, 1'b1);
    l4 = ref_label({1'b0, r[4:1], 1'b0}, m_sel4, 1'b0);
    it.tag = tag;
    it.g  = (l6 < 0) ? 6'd0 : 6'(1 << l6);
    it.i  = (l6 < 0) ? 3'd0 : 3'(l6);
    it.v  = (r != 0);
    it.s  = m_sel;
    it.g4 = (l4 < 0) ? 4'd0 : 4'(1 << (l4 - 1));
    it.i4 = (l4 < 0) ? 3'd0 : 3'(l4);
    it.v4 = (r[4:1] != 0);
    it.s4 = m_sel4;
    sb.push_back(it);
    if (rst) begin m_sel = 0; m_sel4 = 0; end
    else begin
      if (we) m_sel = wd;
      else if (m && sv && l6 >= 1 && l6 <= 4) m_sel = 2'(l6 % 4);
      if (we) m_sel4 = wd;
      else if (m && sv && l4 >= 1) m_sel4 = 2'(l4 % 4);
    end
  endtask

  // Monitor: combinational outputs and the select register, sampled mid low phase.
  initial begin
    forever begin
      @(negedge clk);
      #5;
      if (sb.size() > 0) begin
        item_t e;
        e = sb.pop_front();
        cmp(e.tag, "grant", int'(grant), int'(e.g));
        cmp(e.tag, "win_idx", int'(win_idx), int'(e.i));
        cmp(e.tag, "valid", int'(valid), int'(e.v));
        cmp(e.tag, "sel_q", int'(sel_q), int'(e.s));
        cmp({e.tag, " R10"}, "grant4", int'(grant4), int'(e.g4));
        cmp({e.tag, " R10"}, "win_idx4", int'(win_idx4), int'(e.i4));
        cmp({e.tag, " R10"}, "valid4", int'(valid4), int'(e.v4));
        cmp({e.tag, " R10"}, "sel_q4", int'(sel_q4), int'(e.s4));
      end
    end
  end

  initial begin
    #(20 * 200000);
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog R0 actual=hung expected=finish");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin
    // R9 reset state, R3 idle
    step("R9 reset", 6'b000000, 0, 1, 2'd3, 0);
    step("R9 reset", 6'b000000, 0, 0, 2'd0, 0);
    @(negedge clk); rst = 1'b0;
    step("R9 after reset", 6'b000000, 0, 0, 2'd0, 0);
    // R1 default order
    step("R1 all", 6'b111111, 0, 0, 2'd0, 0);
    step("R1 no0", 6'b111110, 0, 0, 2'd0, 0);
    step("R1 3and4", 6'b011000, 0, 0, 2'd0, 0);
    step("R1 only5", 6'b100000, 0, 0, 2'd0, 0);
    step("R1 0and5", 6'b100001, 0, 0, 2'd0, 0);
    // R2 other selects loaded by write (R8)
    step("R8 wr01", 6'b000000, 0, 1, 2'd1, 0);
    step("R2 sel01 1,4", 6'b010010, 0, 0, 2'd0, 0);
    step("R2 sel01 1,5", 6'b100010, 0, 0, 2'd0, 0);
    step("R8 wr10", 6'b000000, 0, 1, 2'd2, 0);
    step("R2 sel10 1,2", 6'b000110, 0, 0, 2'd0, 0);
    step("R2 sel10 0,4", 6'b010001, 0, 0, 2'd0, 0);
    step("R8 wr11", 6'b000000, 0, 1, 2'd3, 0);
    step("R2 sel11 1,2,3", 6'b001110, 0, 0, 2'd0, 0);
    step("R2 sel11 mid", 6'b011110, 0, 0, 2'd0, 0);
    // R5 fixed mode service does not move select
    step("R5 svc fixed", 6'b011110, 0, 0, 2'd0, 1);
    step("R5 svc fixed", 6'b000110, 0, 0, 2'd0, 1);
    step("R5 check", 6'b011110, 0, 0, 2'd0, 0);
    // R6 rotation round robin over middle
    step("R6 rot", 6'b011110, 1, 0, 2'd0, 1);
    step("R6 rot", 6'b011110, 1, 0, 2'd0, 1);
    step("R6 rot", 6'b011110, 1, 0, 2'd0, 1);
    step("R6 rot", 6'b011110, 1, 0, 2'd0, 1);
    step("R6 rot 3", 6'b001000, 1, 0, 2'd0, 1);
    step("R6 rot 2", 6'b000100, 1, 0, 2'd0, 1);
    step("R6 check", 6'b011110, 1, 0, 2'd0, 0);
    // R7 ends do not rotate (the four-way copy sees a middle winner)
    step("R7 svc0", 6'b000001, 1, 0, 2'd0, 1);
    step("R7 svc5", 6'b100000, 1, 0, 2'd0, 1);
    step("R7 svc0 mid", 6'b010011, 1, 0, 2'd0, 1);
    step("R7 check", 6'b011110, 1, 0, 2'd0, 0);
    // R3 idle service does not rotate
    step("R3 idle svc", 6'b000000, 1, 0, 2'd0, 1);
    step("R3 check", 6'b000000, 1, 0, 2'd0, 0);
    // R8 write beats rotation
    step("R8 wr+svc", 6'b000010, 1, 1, 2'd3, 1);
    step("R8 check", 6'b011110, 1, 0, 2'd0, 0);
    step("R8 wr+svc", 6'b010000, 1, 1, 2'd2, 1);
    step("R4 check", 6'b110100, 0, 0, 2'd0, 0);
    step("R4 drain", 6'b000000, 0, 0, 2'd0, 0);
    @(negedge clk); @(negedge clk);
    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule